// File: doc/BRIEF.md
# Mesh Router Route Computation with One-Hop Misroute Fallback

This block is the route computation stage of one router in a two-dimensional mesh where every end node attaches to up to four routers. Router (x, y) owns four internal (ejection) ports, which reach the nodes at (x, y), (x+1, y), (x, y+1) and (x+1, y+1). Node (x, y) can therefore be reached from routers x-1..x in one dimension and y-1..y in the other. North is increasing y and east is increasing x. For each head flit the block takes the arrival port, the router's own coordinates, the destination node's coordinates and per-output occupancy and power flags. One cycle later it returns an output port and a virtual channel class, or a retry indication.

In deterministic operation the X-then-Y minimal port is chosen when it is free. When that port is unavailable, a small fixed set of one-hop detours is tried, depending on the arrival side. None of these detours turns from vertical to horizontal travel, and east/west detours win over north/south ones. In adaptive operation any free productive minimal port is picked pseudo-randomly and tagged with the adaptive channel class. If no such port is free, the deterministic result is used on the escape class.

Top module: `mesh_route_compute`

## Requirements
- R1: Ports are one-hot over 8 bits: bit0 N, bit1 E, bit2 S, bit3 W, bits4..7 internal ports L0..L3. With dx = dst_x - cur_x and dy = dst_y - cur_y, the deterministic minimal port is E if dx > 1, else W if dx < 0, else N if dy > 1, else S if dy < 0, else an internal port. It is returned whenever free, on the escape class (res_vc = 0).
- R2: When dx and dy are both in {0,1}, the minimal port is internal port L(2*dy + dx).
- R3: An output counts as unavailable when its busy flag is 1 or its power flag is 0. A returned port is never unavailable in the cycle the request was presented.
- R4: If the minimal port is unavailable and the flit arrived on W with dx = 1, the candidates are E plus N (dy >= 1) or S (dy <= 0). For arrival on E with dx = 0, the candidates are W plus N or S by the same rule. Without these conditions an E/W arrival has no candidates.
- R5: A flit that arrived on S may detour only N, and only when dy >= 1. A flit that arrived on N may detour only S, and only when dy <= 0. After arrival on N or S the result is never E or W.
- R6: Among free candidates, E or W is chosen ahead of N or S.
- R7: If neither the minimal port nor any candidate is free, res_retry = 1 with res_port = 0 and res_vc = 0.
- R8: The result never leaves on the side the flit arrived from.
- R9: With req_adaptive = 1, if any productive minimal port is free, one of them is returned with res_vc = 1. The productive ports are E (dx>1), W (dx<0), N (dy>1), S (dy<0) and the internal port of R2. Over repeated requests the choice between two free productive ports varies.
- R10: With req_adaptive = 1 and no productive port free, the deterministic result of R1 to R7 is returned with res_vc = 0.
- R11: A request presented at a clock edge yields res_valid = 1 after that edge and res_valid = 0 when no request was presented. Reset clears res_valid, res_port, res_vc and res_retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Head flit present for routing |
| req_arrive | input | 8 | One-hot arrival port |
| req_adaptive | input | 1 | 1 selects adaptive operation |
| cur_x | input | CW | Router column |
| cur_y | input | CW | Router row |
| dst_x | input | CW | Destination node column |
| dst_y | input | CW | Destination node row |
| port_busy | input | 8 | Output currently transmitting |
| port_on | input | 8 | Downstream input port powered |
| res_valid | output | 1 | Result present |
| res_port | output | 8 | One-hot chosen output, zero on retry |
| res_vc | output | 1 | 1 adaptive class, 0 escape class |
| res_retry | output | 1 | No port available, route again |

## Verification
The turn assertions assume that the arrival port agrees with an X-then-Y path. A flit from W has dx >= 0 and a flit from E has dx <= 1. A flit from S has dx in {0,1} and dy >= 0, and a flit from N has dx in {0,1} and dy <= 1. The stimulus only builds requests that meet these rules, with injections arriving on internal ports. The availability assertion compares the result against the busy and power flags sampled with the request, so the bench holds those flags with each request.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
    localparam int NDIR  = 4;
    localparam int NLOC  = 4;
    localparam int NPORT = NDIR + NLOC;

    typedef enum int {DIR_N = 0, DIR_E = 1, DIR_S = 2, DIR_W = 3} dir_e;
    typedef enum logic {VC_ESCAPE = 1'b0, VC_ADAPT = 1'b1} vc_e;

    typedef logic [NPORT-1:0] pmask_t;

    typedef struct packed {
        logic   retry;
        vc_e    vc;
        pmask_t port;
    } route_t;

    function automatic pmask_t dir_bit(input dir_e d);
        pmask_t m;
        m = '0;
        m[int'(d)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/mrc_port_avail.sv
module mrc_port_avail
    import mrc_pkg::*;
(
    input  pmask_t busy,
    input  pmask_t powered,
    output pmask_t free
);
    for (genvar k = 0; k < NPORT; k++) begin : g_free
        assign free[k] = powered[k] & ~busy[k];
    end
endmodule

// File: rtl/mrc_route_det.sv
module mrc_route_det
    import mrc_pkg::*;
#(
    parameter int CW = 3
) (
    input  pmask_t        arrive,
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  pmask_t        free,
    output pmask_t        prod,
    output pmask_t        det_port
);
    logic signed [CW:0] off_x, off_y;
    logic go_e, go_w, go_n, go_s, at_dest, north;
    logic [1:0] loc_idx;
    logic [NLOC-1:0] loc_vec;
    pmask_t min_port, cand, avail;

    assign off_x = $signed({1'b0, dst_x}) - $signed({1'b0, cur_x});
    assign off_y = $signed({1'b0, dst_y}) - $signed({1'b0, cur_y});

    assign go_e    = off_x > 1;
    assign go_w    = off_x < 0;
    assign go_n    = off_y > 1;
    assign go_s    = off_y < 0;
    assign at_dest = !go_e && !go_w && !go_n && !go_s;
    assign north   = off_y > 0;
    assign loc_idx = {off_y[0], off_x[0]};

    for (genvar k = 0; k < NLOC; k++) begin : g_loc
        assign loc_vec[k] = at_dest && (loc_idx == 2'(k));
    end

    always_comb begin
        prod = '0;
        prod[int'(DIR_E)] = go_e;
        prod[int'(DIR_W)] = go_w;
        prod[int'(DIR_N)] = go_n;
        prod[int'(DIR_S)] = go_s;
        prod[NPORT-1:NDIR] = loc_vec;
    end

    always_comb begin
        min_port = '0;
        if (go_e)      min_port = dir_bit(DIR_E);
        else if (go_w) min_port = dir_bit(DIR_W);
        else if (go_n) min_port = dir_bit(DIR_N);
        else if (go_s) min_port = dir_bit(DIR_S);
        else           min_port[NPORT-1:NDIR] = loc_vec;
    end

    always_comb begin
        cand = '0;
        if (arrive[int'(DIR_W)] && off_x == 1) begin
            cand[int'(DIR_E)] = 1'b1;
            cand[int'(DIR_N)] = north;
            cand[int'(DIR_S)] = !north;
        end
        if (arrive[int'(DIR_E)] && off_x == 0) begin
            cand[int'(DIR_W)] = 1'b1;
            cand[int'(DIR_N)] = north;
            cand[int'(DIR_S)] = !north;
        end
        if (arrive[int'(DIR_S)] && north)  cand[int'(DIR_N)] = 1'b1;
        if (arrive[int'(DIR_N)] && !north) cand[int'(DIR_S)] = 1'b1;
    end

    assign avail = cand & free;

    always_comb begin
        if ((min_port & free) != '0)      det_port = min_port;
        else if (avail[int'(DIR_E)])      det_port = dir_bit(DIR_E);
        else if (avail[int'(DIR_W)])      det_port = dir_bit(DIR_W);
        else if (avail[int'(DIR_N)])      det_port = dir_bit(DIR_N);
        else if (avail[int'(DIR_S)])      det_port = dir_bit(DIR_S);
        else                              det_port = '0;
    end
endmodule

// File: rtl/mrc_rand_pick.sv
module mrc_rand_pick
    import mrc_pkg::*;
#(
    parameter int          LW   = 8,
    parameter logic [LW-1:0] TAPS = 8'hB8,
    parameter logic [LW-1:0] SEED = 8'h5A
) (
    input  logic   clk,
    input  logic   rst,
    input  pmask_t cand,
    output pmask_t pick
);
    logic [LW-1:0] lfsr;
    int start;

    always_ff @(posedge clk) begin
        if (rst)          lfsr <= SEED;
        else if (lfsr[0]) lfsr <= (lfsr >> 1) ^ TAPS;
        else              lfsr <= lfsr >> 1;
    end

    assign start = int'(lfsr) % NPORT;

    always_comb begin
        logic found;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NPORT; k++) begin
            int idx;
            idx = (start + k) % NPORT;
            if (!found && cand[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    // R9
    pick_member_chk: assert property (@(posedge clk) disable iff (rst)
        (cand != '0) |-> ($onehot(pick) && ((pick & ~cand) == '0)));
endmodule

// File: rtl/mesh_route_compute.sv
module mesh_route_compute
    import mrc_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [7:0]    req_arrive,
    input  logic          req_adaptive,
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [7:0]    port_busy,
    input  logic [7:0]    port_on,
    output logic          res_valid,
    output logic [7:0]    res_port,
    output logic          res_vc,
    output logic          res_retry
);
    pmask_t free_m, prod_p, det_p, ad_p, ad_cand;
    pmask_t q_arrive;
    route_t nxt, cur;
    logic   use_ad;

    mrc_port_avail u_avail (
        .busy    (port_busy),
        .powered (port_on),
        .free    (free_m)
    );

    mrc_route_det #(.CW(CW)) u_det (
        .arrive   (req_arrive),
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .dst_x    (dst_x),
        .dst_y    (dst_y),
        .free     (free_m),
        .prod     (prod_p),
        .det_port (det_p)
    );

    assign ad_cand = prod_p & free_m;

    mrc_rand_pick u_pick (
        .clk  (clk),
        .rst  (rst),
        .cand (ad_cand),
        .pick (ad_p)
    );

    always_comb begin
        use_ad    = req_adaptive && (ad_cand != '0);
        nxt.port  = use_ad ? ad_p : det_p;
        nxt.vc    = use_ad ? VC_ADAPT : VC_ESCAPE;
        nxt.retry = (nxt.port == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            cur       <= '{retry: 1'b0, vc: VC_ESCAPE, port: '0};
            q_arrive  <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                cur      <= nxt;
                q_arrive <= req_arrive;
            end
        end
    end

    assign res_port  = cur.port;
    assign res_vc    = cur.vc;
    assign res_retry = cur.retry;

    // R1
    onehot_port_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_retry) |-> $onehot(res_port));
    // R3
    free_port_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((res_port & ($past(port_busy) | ~$past(port_on))) == '0));
    // R5
    no_yx_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (q_arrive[int'(DIR_N)] || q_arrive[int'(DIR_S)]))
        |-> !(res_port[int'(DIR_E)] || res_port[int'(DIR_W)]));
    // R7
    retry_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_retry) |-> (res_port == '0 && res_vc == VC_ESCAPE));
    // R8
    no_uturn_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((res_port[NDIR-1:0] & q_arrive[NDIR-1:0]) == '0));
    // R10
    adaptive_vc_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_vc == VC_ADAPT) |-> $past(req_adaptive));
endmodule

// File: tb/test_mesh_route_compute.sv
`timescale 1ns/1ps
module test_mesh_route_compute;
    localparam logic [7:0] PN = 8'h01, PE = 8'h02, PS = 8'h04, PW = 8'h08;
    localparam logic [7:0] L0 = 8'h10, L1 = 8'h20, L2 = 8'h40, L3 = 8'h80;

    typedef struct {
        logic [7:0] mask;
        logic       vc;
        logic       retry;
        string      tag;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_adaptive = 1'b0;
    logic [7:0] req_arrive = '0, port_busy = '0, port_on = '1;
    logic [2:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic res_valid, res_vc, res_retry;
    logic [7:0] res_port;

    exp_t exp_q[$];
    int checks = 0, errors = 0;
    logic [7:0] seen_rand = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mesh_route_compute #(.CW(3)) i_mesh_route_compute (
        .clk, .rst, .req_valid, .req_arrive, .req_adaptive,
        .cur_x, .cur_y, .dst_x, .dst_y, .port_busy, .port_on,
        .res_valid, .res_port, .res_vc, .res_retry
    );

    task automatic req(input logic [7:0] arr, input int dx, input int dy,
                       input logic [7:0] busy, input logic [7:0] off, input bit ad,
                       input logic [7:0] mask, input bit vc, input bit rty,
                       input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_arrive = arr; req_adaptive = ad;
        cur_x = 3'd2; cur_y = 3'd2; dst_x = 3'(dx); dst_y = 3'(dy);
        port_busy = busy; port_on = ~off;
        e.mask = mask; e.vc = vc; e.retry = rty; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; port_busy = '0; port_on = '1;
    endtask

    // Scoreboard monitor
    always begin
        @(negedge clk);
        #1;
        if (!rst && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 stray result: got valid=1 port=%h expected valid=0", res_port);
            end else begin
                exp_t e;
                bit ok;
                e = exp_q.pop_front();
                if (e.retry)
                    ok = res_retry && res_port == 8'h00 && res_vc == 1'b0;
                else
                    ok = !res_retry && $onehot(res_port) && ((res_port & ~e.mask) == 8'h00)
                         && res_vc == e.vc;
                if (e.tag == "R9rand") seen_rand |= res_port;
                if (!ok) begin
                    errors++;
                    $display("FAIL %s: got port=%h vc=%0d retry=%0d expected port in %h vc=%0d retry=%0d",
                             e.tag, res_port, res_vc, res_retry, e.mask, e.vc, e.retry);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (res_valid !== 1'b0 || res_port !== 8'h00 || res_vc !== 1'b0 || res_retry !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: got v=%b p=%h vc=%b r=%b expected all zero",
                     res_valid, res_port, res_vc, res_retry);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1 minimal dimension-order ports
        req(PW, 5, 2, 8'h00, 8'h00, 0, PE, 0, 0, "R1 east");
        req(PE, 0, 3, 8'h00, 8'h00, 0, PW, 0, 0, "R1 west");
        req(PS, 2, 5, 8'h00, 8'h00, 0, PN, 0, 0, "R1 north");
        req(PN, 3, 0, 8'h00, 8'h00, 0, PS, 0, 0, "R1 south");
        // R2 internal port index
        req(L0, 3, 3, 8'h00, 8'h00, 0, L3, 0, 0, "R2 L3");
        req(PW, 2, 2, 8'h00, 8'h00, 0, L0, 0, 0, "R2 L0");
        req(PS, 3, 2, 8'h00, 8'h00, 0, L1, 0, 0, "R2 L1");
        // R4 and R6 west arrival detours
        req(PW, 3, 3, L3, 8'h00, 0, PE, 0, 0, "R4 W-arrival north E");
        req(PW, 3, 3, L3 | PE, 8'h00, 0, PN, 0, 0, "R6 W-arrival fallback N");
        req(PW, 3, 3, L3 | PE | PN, 8'h00, 0, 8'h00, 0, 1, "R7 all busy");
        req(PW, 3, 2, L1, 8'h00, 0, PE, 0, 0, "R4 W-arrival south E");
        req(PW, 3, 2, L1 | PE, 8'h00, 0, PS, 0, 0, "R6 W-arrival fallback S");
        // R4 east arrival detours
        req(PE, 2, 2, L0, 8'h00, 0, PW, 0, 0, "R4 E-arrival south W");
        req(PE, 2, 2, L0 | PW, 8'h00, 0, PS, 0, 0, "R6 E-arrival fallback S");
        req(PE, 2, 3, L2, 8'h00, 0, PW, 0, 0, "R4 E-arrival north W");
        req(PE, 2, 3, L2 | PW, 8'h00, 0, PN, 0, 0, "R6 E-arrival fallback N");
        req(PW, 5, 3, PE, 8'h00, 0, 8'h00, 0, 1, "R4 no detour far column");
        // R5 vertical arrivals
        req(PS, 2, 3, L2, 8'h00, 0, PN, 0, 0, "R5 S-arrival N only");
        req(PS, 2, 3, L2 | PN, 8'h00, 0, 8'h00, 0, 1, "R5 S-arrival no E/W");
        req(PN, 2, 3, L2, 8'h00, 0, 8'h00, 0, 1, "R5 N-arrival north none");
        req(PN, 2, 2, L0, 8'h00, 0, PS, 0, 0, "R5 N-arrival S");
        // R8 no U-turn
        req(PE, 2, 2, L0 | PW | PS, 8'h00, 0, 8'h00, 0, 1, "R8 no return east");
        // R3 powered-down counts as busy
        req(PW, 3, 3, 8'h00, L3, 0, PE, 0, 0, "R3 off internal");
        req(PW, 5, 2, 8'h00, PE, 0, 8'h00, 0, 1, "R3 off east");
        // R9 and R10 adaptive
        req(L0, 5, 5, 8'h00, 8'h00, 1, PE | PN, 1, 0, "R9 adaptive two");
        req(L0, 5, 5, PE, 8'h00, 1, PN, 1, 0, "R9 adaptive north");
        req(L0, 3, 3, 8'h00, 8'h00, 1, L3, 1, 0, "R9 adaptive eject");
        req(L0, 5, 5, PE | PN, 8'h00, 1, 8'h00, 0, 1, "R10 adaptive retry");
        req(PW, 3, 4, PN, 8'h00, 1, PE, 0, 0, "R10 escape detour");
        for (int i = 0; i < 40; i++)
            req(L0, 5, 5, 8'h00, 8'h00, 1, PE | PN, 1, 0, "R9rand");
        idle();
        idle();
        idle();
        #1;
        checks++;
        if (res_valid !== 1'b0 || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 drain: got valid=%b pending=%0d expected valid=0 pending=0",
                     res_valid, exp_q.size());
        end
        checks++;
        if (seen_rand != (PE | PN)) begin
            errors++;
            $display("FAIL R9 random spread: got seen=%h expected %h", seen_rand, PE | PN);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule